// File: doc/BRIEF.md
# Repeat-Mode Alarm Comparator with Flag

This block decides when a calendar alarm goes off. It compares five BCD time fields (month, day of month, hour, minute, second) from the time counter with five programmed alarm fields. A five-bit repeat code selects how many of those fields take part in the comparison. The comparison is only made on the cycle in which the time counter signals a new second. When the selected fields all match, a sticky alarm flag is set.

One open-drain style output serves two purposes. When the interrupt enable is set, it goes low while the flag is set. When the interrupt enable is clear, it simply copies a general-purpose output level bit. The host clears the flag with a read strobe. While the host's address pointer sits on the flag register, a match is held pending and is not shown in the flag until the pointer moves away. This stops the flag from changing under a read that is in progress. Register decoding and time counting live in neighbouring blocks.

Top module: `alarm_match_irq`

## Requirements
- R1: During and after reset the flag is 0 and no match is pending. With the enable at 0 and the output level at 1, which are the power-up values the register block supplies, the pin is high.
- R2: Repeat code 5'b11111 sets the flag on every second pulse, whatever the field values.
- R3: Repeat code 5'b11110 sets the flag on a second pulse when the seconds field equals its alarm field, and compares nothing else.
- R4: Repeat code 5'b11100 compares seconds and minutes only.
- R5: Repeat code 5'b11000 compares seconds, minutes and hours only.
- R6: Repeat code 5'b10000 compares seconds, minutes, hours and day of month only.
- R7: Repeat code 5'b00000 compares all five fields, including month.
- R8: Any other repeat code behaves as 5'b11111, so the flag is set on every second pulse.
- R9: The comparison is made only in a cycle where sec_tick is 1. The flag becomes visible in the cycle after that clock edge. A match without a pulse sets nothing.
- R10: When flag_rd is 1 in a cycle, the flag is 0 from the next cycle on, unless a set takes effect in that same cycle.
- R11: A match that occurs while ptr_at_flag is 1 leaves the flag unchanged and is held pending. The flag is set in the cycle after the first cycle in which ptr_at_flag is 0.
- R12: With irq_en at 1, irq_n is low exactly while the flag is set. With irq_en at 0, irq_n equals out_level.
- R13: When a set and flag_rd fall in the same cycle, the set wins and the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse per new second |
| tm_sec | input | FW | Running seconds, BCD |
| tm_min | input | FW | Running minutes, BCD |
| tm_hour | input | FW | Running hours, BCD |
| tm_date | input | FW | Running day of month, BCD |
| tm_mon | input | FW | Running month, BCD |
| al_sec | input | FW | Alarm seconds |
| al_min | input | FW | Alarm minutes |
| al_hour | input | FW | Alarm hours |
| al_date | input | FW | Alarm day of month |
| al_mon | input | FW | Alarm month |
| rpt_code | input | 5 | Repeat code; bit 4 is the most significant repeat bit |
| irq_en | input | 1 | Routes the flag to the pin when 1 |
| out_level | input | 1 | Pin level when irq_en is 0 |
| flag_rd | input | 1 | Host read of the flag register; clears the flag |
| ptr_at_flag | input | 1 | Host pointer currently addresses the flag register |
| alarm_flag | output | 1 | Sticky alarm flag |
| irq_n | output | 1 | Active-low interrupt or general output |

## Verification
A set, a clear, or the release of a pending match shows in alarm_flag one clock after the edge that samples the cause. irq_n follows alarm_flag, irq_en and out_level with no extra delay. The bench drives inputs just after the falling edge. A behavioural reference advances on the rising edge, and the flag and the pin are compared with it at every falling edge, which lands exactly one edge after each cause. Directed checks also sample the flag at the first falling edge after a pulse, and again several cycles into a deferral.

// File: rtl/alarm_match_irq.sv
module alarm_match_irq #(
  parameter int FW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sec_tick,
  input  logic [FW-1:0] tm_sec,
  input  logic [FW-1:0] tm_min,
  input  logic [FW-1:0] tm_hour,
  input  logic [FW-1:0] tm_date,
  input  logic [FW-1:0] tm_mon,
  input  logic [FW-1:0] al_sec,
  input  logic [FW-1:0] al_min,
  input  logic [FW-1:0] al_hour,
  input  logic [FW-1:0] al_date,
  input  logic [FW-1:0] al_mon,
  input  logic [4:0]    rpt_code,
  input  logic          irq_en,
  input  logic          out_level,
  input  logic          flag_rd,
  input  logic          ptr_at_flag,
  output logic          alarm_flag,
  output logic          irq_n
);

  logic [4:0] eq, mask;
  logic       hit, fire, set_now, pending;

  assign eq = {tm_mon == al_mon, tm_date == al_date, tm_hour == al_hour,
               tm_min == al_min, tm_sec == al_sec};

  always_comb begin
    case (rpt_code)
      5'b11110: mask = 5'b00001;
      5'b11100: mask = 5'b00011;
      5'b11000: mask = 5'b00111;
      5'b10000: mask = 5'b01111;
      5'b00000: mask = 5'b11111;
      default:  mask = 5'b00000;
    endcase
  end

  assign hit     = &(eq | ~mask);
  assign fire    = sec_tick & hit;
  assign set_now = (fire | pending) & ~ptr_at_flag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alarm_flag <= 1'b0;
      pending    <= 1'b0;
    end else begin
      pending <= (pending | fire) & ptr_at_flag;
      if (set_now)      alarm_flag <= 1'b1;
      else if (flag_rd) alarm_flag <= 1'b0;
    end
  end

  assign irq_n = irq_en ? ~alarm_flag : out_level;

  p_every_sec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick && rpt_code == 5'b11111 && !ptr_at_flag |=> alarm_flag);

  p_tick_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_flag) |-> $past(sec_tick) || $past(pending));

  p_read_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flag_rd && ptr_at_flag |=> !alarm_flag);

  p_hold_at_ptr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_at_flag && !alarm_flag |=> !alarm_flag);

  p_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pending && !ptr_at_flag |=> alarm_flag);

endmodule

// File: tb/sim_alarm_match_irq.sv
`timescale 1ns/1ps
module sim_alarm_match_irq;
  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic sec_tick = 0, irq_en = 0, out_level = 1, flag_rd = 0, ptr_at_flag = 0;
  logic [4:0] rpt_code = 5'b11111;
  logic [7:0] tf [5];
  logic [7:0] af [5];
  logic alarm_flag, irq_n;

  int errors = 0, checks = 0;
  string cur_req = "R1";
  bit done = 0;
  bit m_flag = 0, m_pend = 0;

  alarm_match_irq u0 (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
    .tm_sec(tf[0]), .tm_min(tf[1]), .tm_hour(tf[2]), .tm_date(tf[3]), .tm_mon(tf[4]),
    .al_sec(af[0]), .al_min(af[1]), .al_hour(af[2]), .al_date(af[3]), .al_mon(af[4]),
    .rpt_code(rpt_code), .irq_en(irq_en), .out_level(out_level),
    .flag_rd(flag_rd), .ptr_at_flag(ptr_at_flag),
    .alarm_flag(alarm_flag), .irq_n(irq_n));

  function automatic int depth(input logic [4:0] c);
    case (c)
      5'b11110: return 1;
      5'b11100: return 2;
      5'b11000: return 3;
      5'b10000: return 4;
      5'b00000: return 5;
      default:  return 0;
    endcase
  endfunction

  function automatic bit ref_match();
    for (int i = 0; i < depth(rpt_code); i++)
      if (tf[i] !== af[i]) return 0;
    return 1;
  endfunction

  always @(posedge clk) begin
    bit set;
    if (!rst_n) begin
      m_flag = 0; m_pend = 0;
    end else begin
      set = 0;
      if (sec_tick && ref_match()) begin
        if (ptr_at_flag) m_pend = 1; else set = 1;
      end
      if (m_pend && !ptr_at_flag) begin set = 1; m_pend = 0; end
      if (set) m_flag = 1; else if (flag_rd) m_flag = 0;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    chk(cur_req, alarm_flag, m_flag, "flag vs model");
    chk(cur_req, irq_n, irq_en ? !m_flag : out_level, "pin vs model");
  end

  task automatic cyc(input int n = 1);
    repeat (n) @(negedge clk);
    #0.5;
  endtask

  task automatic tick();
    sec_tick = 1; cyc(); sec_tick = 0;
  endtask

  task automatic clear_flag();
    flag_rd = 1; ptr_at_flag = 1; cyc();
    flag_rd = 0; ptr_at_flag = 0; cyc();
  endtask

  task automatic same_all();
    for (int i = 0; i < 5; i++) begin af[i] = 8'h10 + 8'(i); tf[i] = af[i]; end
  endtask

  task automatic mode_test(input logic [4:0] code, input string req);
    int n;
    cur_req = req; rpt_code = code; n = depth(code);
    same_all(); tick();
    chk(req, alarm_flag, 1'b1, "full match sets");
    clear_flag();
    tf[n-1] = tf[n-1] + 8'h01; tick();
    chk(req, alarm_flag, 1'b0, "deepest compared field differs");
    cyc(2);
    if (n < 5) begin
      same_all(); tf[n] = tf[n] + 8'h01; tick();
      chk(req, alarm_flag, 1'b1, "uncompared field ignored");
      clear_flag();
    end
  endtask

  initial begin
    same_all();
    cyc(3);
    chk("R1", alarm_flag, 1'b0, "flag in reset");
    chk("R1", irq_n, 1'b1, "pin in reset");
    rst_n = 1; cyc(2);
    chk("R1", alarm_flag, 1'b0, "flag after reset");

    cur_req = "R12"; out_level = 0; cyc();
    chk("R12", irq_n, 1'b0, "pin follows out_level low");
    out_level = 1; cyc();

    cur_req = "R2"; rpt_code = 5'b11111;
    tf[0] = 8'h33; tf[4] = 8'h09; tick();
    chk("R2", alarm_flag, 1'b1, "every second sets");
    cur_req = "R10"; clear_flag();
    chk("R10", alarm_flag, 1'b0, "read clears");

    mode_test(5'b11110, "R3");
    mode_test(5'b11100, "R4");
    mode_test(5'b11000, "R5");
    mode_test(5'b10000, "R6");
    mode_test(5'b00000, "R7");

    cur_req = "R8"; rpt_code = 5'b10101; same_all(); tf[0] = 8'h59; tick();
    chk("R8", alarm_flag, 1'b1, "invalid code acts as every second");
    clear_flag();
    rpt_code = 5'b01111; tick();
    chk("R8", alarm_flag, 1'b1, "invalid code 01111");
    clear_flag();

    cur_req = "R9"; rpt_code = 5'b00000; same_all(); cyc(4);
    chk("R9", alarm_flag, 1'b0, "match without pulse");

    cur_req = "R11"; ptr_at_flag = 1; tick(); cyc(3);
    chk("R11", alarm_flag, 1'b0, "deferred while pointer on flag");
    ptr_at_flag = 0; cyc();
    chk("R11", alarm_flag, 1'b1, "released after pointer moves");

    cur_req = "R12"; irq_en = 1; out_level = 0; cyc();
    chk("R12", irq_n, 1'b0, "pin low with flag");
    clear_flag();
    chk("R12", irq_n, 1'b1, "pin released after read");

    cur_req = "R13"; flag_rd = 1; sec_tick = 1; cyc();
    flag_rd = 0; sec_tick = 0;
    chk("R13", alarm_flag, 1'b1, "set wins over read");
    cyc(2);
    irq_en = 0; out_level = 1; clear_flag();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1; errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule